// File: doc/BRIEF.md
# Clock-Gated Register Bank

This block holds `NREG` independent registers of `WIDTH` bits each. Every register has its own load enable. Instead of feeding its own output back through a hold multiplexer, each register receives a gated copy of the clock that pulses only on the edges where its enable is high. Registers that do not load therefore see no clock activity at all.

Two gate circuits are offered, and a parameter picks one of them:

- **Positive style.** A level latch, open while the clock is low, holds the enable. Its output is ANDed with the clock.
- **Negative style.** No latch is used. The inverted enable is ORed with the clock.

Either style gives the same register contents for the same stimulus. Lanes narrower than `MIN_GATE_WIDTH` are not worth a gate, so they fall back to a plain enabled flop on the free-running clock.

A test-mode input forces every lane to load on every edge, as scan shifting needs. It is merged into each enable before the gate, so it cannot cut a clock pulse short. An optional observability register samples the effective per-lane enables on the ungated clock. This makes faults in the enable logic visible at a port.

Stimulus timing: inputs are expected to change while the clock is high.

Top module: `cg_regbank`

## Requirements
- R1: An active-low `rst_n` clears all of `q` and `obs` at once, without waiting for a clock edge, and holds them at zero while low.
- R2: On a rising `clk` edge where `en[i]` is 1, lane i of `q` (bits `i*WIDTH` up to `i*WIDTH+WIDTH-1`) takes the matching slice of `d`.
- R3: On a rising edge where `en[i]` and `test_mode` are both 0, lane i of `q` keeps its value whatever `d` holds.
- R4: Lanes are independent: the enable of one lane never changes the contents of another lane.
- R5: While `test_mode` is 1, every lane loads `d` on each rising edge regardless of `en`.
- R6: With `HAS_OBS` = 1, on each rising `clk` edge `obs[i]` takes `en[i] | test_mode`; with `HAS_OBS` = 0, `obs` is constant 0.
- R7: `NEG_STYLE` = 0 (latch plus AND) and `NEG_STYLE` = 1 (inverted enable ORed with the clock) produce identical `q` for the same stimulus.
- R8: With `WIDTH` below `MIN_GATE_WIDTH`, lanes use an enabled flop on the ungated clock and show the same `q` behaviour as the gated lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Forces every lane to load on every edge |
| en | input | NREG | Per-lane load enable |
| d | input | NREG*WIDTH | Write data, lane i in slice i |
| q | output | NREG*WIDTH | Register contents, lane i in slice i |
| obs | output | NREG | Effective enables sampled on the ungated clock |

## Verification
A lane whose gate is stuck open shows new data in `q` after the first edge on which its enable was low. A lane whose gate is stuck shut shows stale data after the first edge on which it should have loaded. Either error appears on the very next edge. An enable path corrupted upstream of the gate, for example a lost test override, shows in `obs` one edge later, even for a lane whose data happens to repeat. A latch that samples in the wrong phase, or an OR gate built with the wrong polarity, makes the two styles disagree. A wrong fallback choice for narrow lanes makes the multiplexer build disagree. The bench runs all three builds side by side against one reference model, so each of these faults shows as a mismatch on the next edge.

// File: rtl/cg_regbank.sv
module cg_regbank #(
  parameter int NREG           = 4,
  parameter int WIDTH          = 8,
  parameter int MIN_GATE_WIDTH = 4,
  parameter bit NEG_STYLE      = 1'b0,
  parameter bit HAS_OBS        = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  test_mode,
  input  logic [NREG-1:0]       en,
  input  logic [NREG*WIDTH-1:0] d,
  output logic [NREG*WIDTH-1:0] q,
  output logic [NREG-1:0]       obs
);
  localparam bit GATED = (WIDTH >= MIN_GATE_WIDTH);

  logic [NREG-1:0] en_eff;
  assign en_eff = en | {NREG{test_mode}};

  for (genvar i = 0; i < NREG; i++) begin : g_lane
    logic [WIDTH-1:0] r;
    assign q[i*WIDTH +: WIDTH] = r;

    if (GATED) begin : g_gated
      logic gclk;
      if (NEG_STYLE) begin : g_or
        assign gclk = clk | ~en_eff[i];
      end else begin : g_and
        logic en_lat;
        always_latch begin
          if (!clk) en_lat <= en_eff[i];
        end
        assign gclk = clk & en_lat;
      end

      always_ff @(posedge gclk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= d[i*WIDTH +: WIDTH];
      end
    end else begin : g_mux
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         r <= '0;
        else if (en_eff[i]) r <= d[i*WIDTH +: WIDTH];
      end
    end
  end

  if (HAS_OBS) begin : g_obs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) obs <= '0;
      else        obs <= en_eff;
    end
  end else begin : g_no_obs
    assign obs = '0;
  end
endmodule

// File: rtl/cg_regbank_chk.sv
module cg_regbank_chk #(
  parameter int NREG    = 4,
  parameter int WIDTH   = 8,
  parameter bit HAS_OBS = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  test_mode,
  input logic [NREG-1:0]       en,
  input logic [NREG*WIDTH-1:0] d,
  input logic [NREG*WIDTH-1:0] q,
  input logic [NREG-1:0]       obs
);
  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> (q == '0 && obs == '0));

  p_test_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> q == $past(d));

  for (genvar i = 0; i < NREG; i++) begin : g_lane
    p_lane_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en[i] |=> q[i*WIDTH +: WIDTH] == $past(d[i*WIDTH +: WIDTH]));
    p_lane_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[i] && !test_mode) |=> $stable(q[i*WIDTH +: WIDTH]));
  end

  if (HAS_OBS) begin : g_obs
    p_obs_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> obs == $past(en | {NREG{test_mode}}));
  end else begin : g_no_obs
    p_obs_zero_r6: assert property (@(posedge clk) obs == '0);
  end
endmodule

bind cg_regbank cg_regbank_chk #(.NREG(NREG), .WIDTH(WIDTH), .HAS_OBS(HAS_OBS)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .en(en), .d(d), .q(q), .obs(obs)
);

// File: tb/tb_cg_regbank.sv
module tb_cg_regbank;
  localparam int NREG = 4;
  localparam int W    = 8;
  localparam int DW   = NREG * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0;
  logic [NREG-1:0] en = '0;
  logic [DW-1:0] d = '0;
  logic [DW-1:0] q_pos, q_neg, q_mux;
  logic [NREG-1:0] obs_pos, obs_neg, obs_mux;

  always #10 clk = ~clk;

  cg_regbank #(.NREG(NREG), .WIDTH(W), .MIN_GATE_WIDTH(4), .NEG_STYLE(1'b0), .HAS_OBS(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .en(en), .d(d), .q(q_pos), .obs(obs_pos));
  cg_regbank #(.NREG(NREG), .WIDTH(W), .MIN_GATE_WIDTH(4), .NEG_STYLE(1'b1), .HAS_OBS(1'b1)) dut_neg (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .en(en), .d(d), .q(q_neg), .obs(obs_neg));
  cg_regbank #(.NREG(NREG), .WIDTH(W), .MIN_GATE_WIDTH(16), .NEG_STYLE(1'b0), .HAS_OBS(1'b1)) dut_mux (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .en(en), .d(d), .q(q_mux), .obs(obs_mux));

  typedef struct {
    logic [DW-1:0]   q;
    logic [NREG-1:0] obs;
    string           tag;
  } exp_t;

  exp_t sb[$];
  logic [DW-1:0] mq = '0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [NREG-1:0] e, input logic [DW-1:0] dv, input logic t, input string tag);
    exp_t it;
    en = e; d = dv; test_mode = t;
    @(posedge clk);
    for (int i = 0; i < NREG; i++)
      if (e[i] | t) mq[i*W +: W] = dv[i*W +: W];
    #2;
    it.q = mq; it.obs = e | {NREG{t}}; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        chk(it.tag, "q latch-and", q_pos, it.q);
        chk(it.tag, "obs", {{(DW-NREG){1'b0}}, obs_pos}, {{(DW-NREG){1'b0}}, it.obs});
        chk({it.tag, "/R7"}, "q latch-free-or", q_neg, it.q);
        chk({it.tag, "/R8"}, "q mux-fallback", q_mux, it.q);
      end
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ace_b00c;
    @(posedge clk); @(posedge clk); #2;
    chk("R1", "reset q", q_pos, '0);
    chk("R1", "reset obs", {{(DW-NREG){1'b0}}, obs_pos}, '0);
    chk("R1", "reset q neg", q_neg, '0);
    rst_n = 1'b1;

    step(4'b1111, 32'hA1B2C3D4, 1'b0, "R2");
    step(4'b0000, 32'h5555AAAA, 1'b0, "R3");
    step(4'b0000, 32'hFFFFFFFF, 1'b0, "R3");
    step(4'b0101, 32'h11223344, 1'b0, "R4");
    step(4'b1010, 32'h99887766, 1'b0, "R4");
    step(4'b0001, 32'h0000_00EE, 1'b0, "R4");
    step(4'b1000, 32'h7F00_0000, 1'b0, "R4");
    step(4'b0000, 32'hDEADBEEF, 1'b1, "R5");
    step(4'b0010, 32'hCAFEF00D, 1'b1, "R5");
    step(4'b0000, 32'h01020304, 1'b0, "R6");
    step(4'b0110, 32'h0BADC0DE, 1'b0, "R6");
    for (int k = 0; k < 40; k++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      step(lfsr[3:0], {lfsr[15:0], lfsr[31:16]} ^ 32'h3C3C3C3C, (lfsr[7:4] == 4'hF), "R7");
    end
    step(4'b1111, 32'h12345678, 1'b0, "R2");

    @(negedge clk); #1;
    rst_n = 1'b0;
    #1;
    chk("R1", "async q", q_pos, '0);
    chk("R1", "async q neg", q_neg, '0);
    chk("R1", "async q mux", q_mux, '0);
    chk("R1", "async obs", {{(DW-NREG){1'b0}}, obs_pos}, '0);
    mq = '0;
    @(posedge clk); #2;
    rst_n = 1'b1;
    step(4'b0000, 32'h87654321, 1'b0, "R3");
    step(4'b0100, 32'h87654321, 1'b0, "R4");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule